// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block sits beside the standard data, status and control registers of a parallel port and runs the enhanced-mode peripheral cycles. A host access to the enhanced address register (offset 3) or the enhanced data register (offset 4) becomes one or more byte cycles on the external 8-bit bus. A cycle starts only when five bits of the control register match the exact pattern the direction of the access requires. Otherwise a write is dropped and a read answers with all ones.

Each byte cycle pulls an address or data strobe low and marks the direction on a write-direction pin. It then waits for the peripheral to pull its wait/acknowledge line low. If no acknowledge comes within a programmable number of clocks, the cycle ends, a sticky timeout flag is set in status bit 0, and any bytes that remain of the access are dropped. Data-register accesses may be 8, 16 or 32 bits wide and are sent least significant byte first.

The host side is a simple request/response port: one request is taken per idle cycle, `busy` covers an enhanced access from start to end, and every accepted request gives exactly one `rspValid` pulse.

Top module: `epp_gate`

## Requirements
- R1: After reset the control register reads 0xCC, status reads 0x00, the bus drives 0xFF with `busOe` high, both strobes and `eppWriteN` are high and `busy` is low.
- R2: A write to offset 2 stores the value with bits 7:6 forced to 1. Bit 5 of the control register selects the idle bus direction: `busOe` is the inverse of bit 5 while no enhanced access runs.
- R3: An enhanced write (offset 3 or 4) runs only when (control & 0x2F) == 0x04. Otherwise no strobe falls, nothing is driven, and the request completes with a response.
- R4: An enhanced read runs only when (control & 0x2F) == 0x24. Otherwise no strobe falls and the response data is all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF for `reqSize` 0, 1 or 2. Offset 3 always counts as 8 bits.
- R5: Offset 3 produces exactly one byte cycle on `addrStrbN`. Offset 4 produces its byte cycles on `dataStrbN`.
- R6: At offset 4, `reqSize` 0/1/2 gives 1/2/4 byte cycles, sent least significant byte first. Read bytes are assembled in the same little-endian order into `rspRdata`.
- R7: During a byte cycle exactly one strobe is low. `eppWriteN` is low for writes, which also drive the byte with `busOe` high, and high for reads. A byte completes at the clock edge where `waitN` is sampled low. Consecutive bytes are separated by at least one clock with the strobes high.
- R8: If `waitN` is not sampled low within `tmoLimit` strobe-low clocks, status bit 0 sets and the remaining bytes are abandoned. A read then returns 0xFF in every byte not received.
- R9: The timeout flag is sticky. Only a status write (offset 1) with bit 0 = 1 clears it; a status write with bit 0 = 0 leaves it set.
- R10: `busy` is high from the clock after an enhanced access is accepted until its response. Requests presented while busy are ignored. `rspValid` is a one-clock pulse, given only while `busy` is low.
- R11: A write to offset 0 loads the output latch driven on the idle bus. A read of offset 0 returns `busIn` when control bit 5 is 1 and the latch when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmoLimit | input | 8 | Strobe-low clocks allowed before timeout |
| reqValid | input | 1 | Host request, taken when `busy` is low |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 3 | Register offset |
| reqSize | input | 2 | Access width: 0 byte, 1 half, 2 word |
| reqWdata | input | 32 | Write data |
| busy | output | 1 | Enhanced access in progress |
| rspValid | output | 1 | Response pulse |
| rspRdata | output | 32 | Read data of the response |
| busOut | output | 8 | Bus value driven |
| busOe | output | 1 | Bus output enable |
| busIn | input | 8 | Bus value received |
| eppWriteN | output | 1 | Low during enhanced write accesses |
| addrStrbN | output | 1 | Address strobe, active low |
| dataStrbN | output | 1 | Data strobe, active low |
| waitN | input | 1 | Peripheral acknowledge, active low |

## Verification
The hardest situation to reach is a timeout in the middle of a multi-byte access: the flag must set, the remaining bytes must be dropped, and the flag must then survive unrelated traffic. The bench peripheral model can hold its acknowledge back for a whole access. Random runs hide the acknowledge on some accesses and vary the control pattern, so gated-off, timed-out and completed accesses of every width are mixed. Status reads and clears are interleaved with these accesses.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam int HOST_W     = 32;
  localparam int HOST_BYTES = HOST_W / 8;
  localparam int BSEL_W     = $clog2(HOST_BYTES);

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTRL = 3'd2;
  localparam logic [2:0] OFS_EADR = 3'd3;
  localparam logic [2:0] OFS_EDAT = 3'd4;

  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam logic [7:0] CTRL_FIXED = 8'hC0;
  localparam logic [7:0] CTRL_RESET = 8'hCC;
  localparam int         DIR_BIT    = 5;

  typedef struct packed {
    logic              accept;
    logic              startXfer;
    logic              capture;
    logic              setTmo;
    logic              finish;
    logic [BSEL_W-1:0] byteSel;
  } epp_strb_t;

  function automatic logic [BSEL_W-1:0] lastByte(input logic [1:0] size);
    case (size)
      2'd0:    lastByte = '0;
      2'd1:    lastByte = BSEL_W'(1);
      default: lastByte = BSEL_W'(HOST_BYTES - 1);
    endcase
  endfunction

  function automatic logic [HOST_W-1:0] widthMask(input logic [1:0] size);
    logic [BSEL_W-1:0] last;
    last = lastByte(size);
    for (int i = 0; i < HOST_BYTES; i++)
      widthMask[i*8 +: 8] = (i <= int'(last)) ? 8'hFF : 8'h00;
  endfunction
endpackage

// File: rtl/epp_gate_ctrl.sv
module epp_gate_ctrl
  import epp_gate_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TMO_W-1:0] tmoLimit,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [2:0]       reqAddr,
  input  logic [1:0]       reqSize,
  input  logic             waitN,
  input  logic             gateWrOk,
  input  logic             gateRdOk,
  output epp_strb_t        strb,
  output logic             busy,
  output logic             strobeLow,
  output logic             addrCyc,
  output logic             writeCyc
);
  typedef enum logic [1:0] {ST_IDLE, ST_STRB, ST_GAP, ST_DONE} state_t;

  state_t            state;
  logic [BSEL_W-1:0] byteIdx, lastIdx;
  logic [TMO_W-1:0]  waitCnt;
  logic              isEpp, accept, start, byteAck, byteTmo;

  assign isEpp   = (reqAddr == OFS_EADR) || (reqAddr == OFS_EDAT);
  assign accept  = (state == ST_IDLE) && reqValid;
  assign start   = accept && isEpp && (reqWrite ? gateWrOk : gateRdOk);
  assign byteAck = (state == ST_STRB) && !waitN;
  assign byteTmo = (state == ST_STRB) && waitN &&
                   ({1'b0, waitCnt} + 1'b1 >= {1'b0, tmoLimit});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      byteIdx  <= '0;
      lastIdx  <= '0;
      waitCnt  <= '0;
      addrCyc  <= 1'b0;
      writeCyc <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_STRB;
          byteIdx  <= '0;
          waitCnt  <= '0;
          lastIdx  <= (reqAddr == OFS_EADR) ? '0 : lastByte(reqSize);
          addrCyc  <= (reqAddr == OFS_EADR);
          writeCyc <= reqWrite;
        end
        ST_STRB: begin
          if (byteAck) begin
            if (byteIdx == lastIdx) state <= ST_DONE;
            else begin
              state   <= ST_GAP;
              byteIdx <= byteIdx + 1'b1;
            end
          end else if (byteTmo) state <= ST_DONE;
          else waitCnt <= waitCnt + 1'b1;
        end
        ST_GAP: begin
          state   <= ST_STRB;
          waitCnt <= '0;
        end
        default: begin
          state    <= ST_IDLE;
          writeCyc <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    strb.accept    = accept;
    strb.startXfer = start;
    strb.capture   = byteAck;
    strb.setTmo    = byteTmo;
    strb.finish    = (state == ST_DONE);
    strb.byteSel   = byteIdx;
  end

  assign busy      = (state != ST_IDLE);
  assign strobeLow = (state == ST_STRB);
endmodule

// File: rtl/epp_gate_dpath.sv
module epp_gate_dpath
  import epp_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  epp_strb_t         strb,
  input  logic              reqWrite,
  input  logic [2:0]        reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [HOST_W-1:0] reqWdata,
  input  logic [7:0]        busIn,
  input  logic              busy,
  input  logic              strobeLow,
  input  logic              addrCyc,
  input  logic              writeCyc,
  output logic              gateWrOk,
  output logic              gateRdOk,
  output logic              rspValid,
  output logic [HOST_W-1:0] rspRdata,
  output logic [7:0]        busOut,
  output logic              busOe,
  output logic              addrStrbN,
  output logic              dataStrbN,
  output logic              eppWriteN,
  output logic              tmoFlag,
  output logic [7:0]        ctrlReg
);
  logic [7:0]        dataLatch;
  logic [HOST_W-1:0] xferBuf;
  logic [1:0]        sizeQ;
  logic [HOST_W-1:0] regRead;
  logic [1:0]        effSize;

  assign gateWrOk = (ctrlReg & GATE_MASK) == GATE_WR;
  assign gateRdOk = (ctrlReg & GATE_MASK) == GATE_RD;
  assign effSize  = (reqAddr == OFS_EADR) ? 2'd0 : reqSize;

  always_comb begin
    case (reqAddr)
      OFS_DATA: regRead = HOST_W'(ctrlReg[DIR_BIT] ? busIn : dataLatch);
      OFS_STAT: regRead = HOST_W'({7'b0, tmoFlag});
      OFS_CTRL: regRead = HOST_W'(ctrlReg);
      OFS_EADR, OFS_EDAT: regRead = widthMask(effSize);
      default:  regRead = HOST_W'(8'hFF);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= CTRL_RESET;
      dataLatch <= 8'hFF;
      tmoFlag   <= 1'b0;
      xferBuf   <= '1;
      sizeQ     <= '0;
      rspValid  <= 1'b0;
      rspRdata  <= '0;
    end else begin
      rspValid <= 1'b0;
      if (strb.startXfer) begin
        xferBuf <= reqWrite ? reqWdata : '1;
        sizeQ   <= effSize;
      end else if (strb.accept) begin
        rspValid <= 1'b1;
        rspRdata <= reqWrite ? '0 : regRead;
        if (reqWrite) begin
          case (reqAddr)
            OFS_DATA: dataLatch <= reqWdata[7:0];
            OFS_STAT: if (reqWdata[0]) tmoFlag <= 1'b0;
            OFS_CTRL: ctrlReg <= reqWdata[7:0] | CTRL_FIXED;
            default: ;
          endcase
        end
      end
      if (strb.capture && !writeCyc) xferBuf[strb.byteSel*8 +: 8] <= busIn;
      if (strb.setTmo) tmoFlag <= 1'b1;
      if (strb.finish) begin
        rspValid <= 1'b1;
        rspRdata <= writeCyc ? '0 : (xferBuf & widthMask(sizeQ));
      end
    end
  end

  assign busOut    = (busy && writeCyc) ? xferBuf[strb.byteSel*8 +: 8] : dataLatch;
  assign busOe     = busy ? writeCyc : !ctrlReg[DIR_BIT];
  assign addrStrbN = !(strobeLow && addrCyc);
  assign dataStrbN = !(strobeLow && !addrCyc);
  assign eppWriteN = !(busy && writeCyc);
endmodule

// File: rtl/epp_gate.sv
module epp_gate
  import epp_gate_pkg::*;
#(
  parameter int TMO_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TMO_W-1:0]  tmoLimit,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [2:0]        reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [HOST_W-1:0] reqWdata,
  output logic              busy,
  output logic              rspValid,
  output logic [HOST_W-1:0] rspRdata,
  output logic [7:0]        busOut,
  output logic              busOe,
  input  logic [7:0]        busIn,
  output logic              eppWriteN,
  output logic              addrStrbN,
  output logic              dataStrbN,
  input  logic              waitN
);
  epp_strb_t  strb;
  logic       strobeLow, addrCyc, writeCyc, gateWrOk, gateRdOk, tmoFlag;
  logic [7:0] ctrlReg;

  epp_gate_ctrl #(.TMO_W(TMO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tmoLimit(tmoLimit), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize), .waitN(waitN),
    .gateWrOk(gateWrOk), .gateRdOk(gateRdOk), .strb(strb), .busy(busy),
    .strobeLow(strobeLow), .addrCyc(addrCyc), .writeCyc(writeCyc)
  );

  epp_gate_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWdata(reqWdata), .busIn(busIn), .busy(busy),
    .strobeLow(strobeLow), .addrCyc(addrCyc), .writeCyc(writeCyc),
    .gateWrOk(gateWrOk), .gateRdOk(gateRdOk), .rspValid(rspValid),
    .rspRdata(rspRdata), .busOut(busOut), .busOe(busOe), .addrStrbN(addrStrbN),
    .dataStrbN(dataStrbN), .eppWriteN(eppWriteN), .tmoFlag(tmoFlag),
    .ctrlReg(ctrlReg)
  );
endmodule

// File: rtl/epp_gate_chk.sv
module epp_gate_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       rspValid,
  input logic       addrStrbN,
  input logic       dataStrbN,
  input logic       eppWriteN,
  input logic       busOe,
  input logic       reqValid,
  input logic       reqWrite,
  input logic [2:0] reqAddr,
  input logic [31:0] reqWdata,
  input logic       tmoFlag,
  input logic [7:0] ctrlReg
);
  logic strobing, clearReq;
  assign strobing = !addrStrbN || !dataStrbN;
  assign clearReq = reqValid && !busy && reqWrite && (reqAddr == 3'd1) && reqWdata[0];

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!addrStrbN, !dataStrbN}));
  assert_write_drives_R7: assert property (@(posedge clk) disable iff (!rstN)
    !eppWriteN |-> busOe);
  assert_gate_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobing && !eppWriteN) |-> ((ctrlReg & 8'h2F) == 8'h04));
  assert_gate_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobing && eppWriteN) |-> ((ctrlReg & 8'h2F) == 8'h24));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (addrStrbN && dataStrbN));
  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !busy);
  assert_tmo_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (tmoFlag && !clearReq) |=> tmoFlag);
  assert_tmo_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmoFlag) |-> $past(strobing));
endmodule

bind epp_gate epp_gate_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .rspValid(rspValid),
  .addrStrbN(addrStrbN), .dataStrbN(dataStrbN), .eppWriteN(eppWriteN),
  .busOe(busOe), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
  .reqWdata(reqWdata), .tmoFlag(tmoFlag), .ctrlReg(ctrlReg)
);

// File: tb/epp_gate_tb.sv
`timescale 1ns/1ps
module epp_gate_tb;
  logic        clk = 0, rstN = 0;
  logic [7:0]  tmoLimit = 8'd8;
  logic        reqValid = 0, reqWrite = 0;
  logic [2:0]  reqAddr = 0;
  logic [1:0]  reqSize = 0;
  logic [31:0] reqWdata = 0;
  logic        busy, rspValid, busOe, eppWriteN, addrStrbN, dataStrbN;
  logic [31:0] rspRdata;
  logic [7:0]  busOut, busIn;
  logic        waitN = 1;

  int tests = 0, fails = 0, cycles = 0;
  int ptr = 0, ptr0 = 0, attempts = 0, att0 = 0, lowCnt = 0;
  logic [7:0] logData [8];
  logic       logAddr [8];
  logic       logWrN  [8];
  logic [7:0] rdBase = 8'h00;
  bit         respond = 1;
  int         delay = 0;

  always #2.5 clk = ~clk;

  epp_gate u_dut (.*);

  assign busIn = rdBase + 8'(ptr - ptr0);

  // peripheral model
  always @(posedge clk) begin
    if (!addrStrbN || !dataStrbN) begin
      if (lowCnt == 0) attempts <= attempts + 1;
      if (!waitN) begin
        logData[ptr % 8] <= busOut;
        logAddr[ptr % 8] <= !addrStrbN;
        logWrN[ptr % 8]  <= eppWriteN;
        ptr <= ptr + 1;
      end
      lowCnt <= lowCnt + 1;
      waitN  <= !(respond && lowCnt >= delay);
    end else begin
      lowCnt <= 0;
      waitN  <= 1'b1;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: act=hung exp=done");
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [2:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    int guard;
    @(negedge clk);
    ptr0 = ptr; att0 = attempts;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqSize = sz; reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    guard = 0;
    while (!rspValid && guard < 200) begin @(negedge clk); guard++; end
    rd = rspRdata;
    @(negedge clk);
  endtask

  function automatic int nBytes(input logic [2:0] a, input logic [1:0] sz);
    if (a == 3'd3) return 1;
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] onesW(input int n);
    return (n == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*n)) - 1);
  endfunction

  function automatic logic [31:0] seqW(input logic [7:0] base, input int n);
    logic [31:0] v = 0;
    for (int i = 0; i < n; i++) v[i*8 +: 8] = base + 8'(i);
    return v;
  endfunction

  logic [31:0] rd;
  logic [7:0]  ctl;
  bit          expTmo;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busOut", busOut, 8'hFF);
    chk("R1 busOe", busOe, 1);
    chk("R1 strobes", {addrStrbN, dataStrbN, eppWriteN, busy}, 4'b1110);
    access(0, 3'd2, 0, 0, rd); chk("R1 ctrl", rd, 32'hCC);
    access(0, 3'd1, 0, 0, rd); chk("R1 status", rd, 32'h00);

    // R2 control write
    access(1, 3'd2, 0, 32'h24, rd);
    access(0, 3'd2, 0, 0, rd); chk("R2 ctrl readback", rd, 32'hE4);
    chk("R2 busOe dir in", busOe, 0);
    access(1, 3'd2, 0, 32'h04, rd);
    chk("R2 busOe dir out", busOe, 1);

    // R5 R7 address write
    access(1, 3'd3, 2'd2, 32'h77_66_55_A5, rd);
    chk("R5 addr attempts", attempts - att0, 1);
    chk("R5 addr strobe", logAddr[ptr0 % 8], 1);
    chk("R7 addr byte", logData[ptr0 % 8], 8'hA5);
    chk("R7 write dir", logWrN[ptr0 % 8], 0);

    // R6 word write, little endian
    delay = 2;
    access(1, 3'd4, 2'd2, 32'h11223344, rd);
    chk("R6 word bytes", ptr - ptr0, 4);
    chk("R6 order", {logData[(ptr0+3)%8], logData[(ptr0+2)%8], logData[(ptr0+1)%8], logData[ptr0%8]}, 32'h11223344);
    chk("R5 data strobe", logAddr[(ptr0+1)%8], 0);

    // R6 R7 reads
    access(1, 3'd2, 0, 32'h24, rd);
    rdBase = 8'h70; delay = 1;
    access(0, 3'd4, 2'd1, 0, rd);
    chk("R6 half read", rd, 32'h7170);
    chk("R7 read dir", logWrN[ptr0 % 8], 1);
    rdBase = 8'h90;
    access(0, 3'd3, 2'd2, 0, rd);
    chk("R5 addr read", rd, 32'h90);

    // R3 write gated off (dir set, then select set)
    access(1, 3'd4, 2'd2, 32'hDEADBEEF, rd);
    chk("R3 gated write dir=1", attempts - att0, 0);
    access(1, 3'd2, 0, 32'h0C, rd);
    access(1, 3'd4, 2'd0, 32'h5A, rd);
    chk("R3 gated write select", attempts - att0, 0);

    // R4 read gated off
    access(1, 3'd2, 0, 32'h04, rd);
    access(0, 3'd4, 2'd0, 0, rd); chk("R4 ones byte", rd, 32'hFF);
    access(0, 3'd4, 2'd1, 0, rd); chk("R4 ones half", rd, 32'hFFFF);
    access(0, 3'd4, 2'd2, 0, rd); chk("R4 ones word", rd, 32'hFFFF_FFFF);
    chk("R4 no strobe", attempts - att0, 0);

    // R8 timeout on write, R9 clear
    respond = 0;
    access(1, 3'd4, 2'd2, 32'hCAFEF00D, rd);
    chk("R8 abandon attempts", attempts - att0, 1);
    chk("R8 no bytes", ptr - ptr0, 0);
    respond = 1;
    access(0, 3'd1, 0, 0, rd); chk("R8 status tmo", rd, 32'h01);
    access(1, 3'd1, 0, 32'hFE, rd);
    access(0, 3'd1, 0, 0, rd); chk("R9 sticky on bit0=0", rd, 32'h01);
    access(1, 3'd4, 2'd0, 32'h33, rd);
    access(0, 3'd1, 0, 0, rd); chk("R9 sticky after good cycle", rd, 32'h01);
    access(1, 3'd1, 0, 32'h01, rd);
    access(0, 3'd1, 0, 0, rd); chk("R9 cleared", rd, 32'h00);

    // R8 timeout on read
    access(1, 3'd2, 0, 32'h24, rd);
    respond = 0;
    access(0, 3'd4, 2'd2, 0, rd); chk("R8 read ones", rd, 32'hFFFF_FFFF);
    respond = 1;
    access(1, 3'd1, 0, 32'h01, rd);

    // R10 busy and ignored request
    access(1, 3'd2, 0, 32'h04, rd);
    delay = 3;
    @(negedge clk);
    ptr0 = ptr;
    reqValid = 1; reqWrite = 1; reqAddr = 3'd4; reqSize = 2'd1; reqWdata = 32'h0000_BBAA;
    @(negedge clk);
    chk("R10 busy after accept", busy, 1);
    reqAddr = 3'd2; reqWdata = 32'h24;
    @(negedge clk);
    reqValid = 0;
    while (!rspValid) @(negedge clk);
    chk("R10 busy low at response", busy, 0);
    @(negedge clk);
    chk("R10 single pulse", rspValid, 0);
    access(0, 3'd2, 0, 0, rd); chk("R10 ignored while busy", rd, 32'hC4);

    // R11 data register
    access(1, 3'd0, 0, 32'h5A, rd);
    chk("R11 latch on bus", busOut, 8'h5A);
    access(0, 3'd0, 0, 0, rd); chk("R11 read latch", rd, 32'h5A);
    access(1, 3'd2, 0, 32'h24, rd);
    rdBase = 8'h3C;
    access(0, 3'd0, 0, 0, rd); chk("R11 read bus", rd, 32'h3C);

    // random mix
    void'($urandom(32'h1234_5678));
    expTmo = 0;
    for (int it = 0; it < 200; it++) begin
      int sel = $urandom % 3;
      bit wr = $urandom % 2;
      logic [2:0] a = ($urandom % 2) ? 3'd3 : 3'd4;
      logic [1:0] sz = 2'($urandom % 3);
      logic [31:0] wd = $urandom;
      int n;
      bit gate;
      ctl = (sel == 0) ? 8'h04 : (sel == 1) ? 8'h24 : 8'($urandom);
      access(1, 3'd2, 0, {24'h0, ctl}, rd);
      respond = ($urandom % 5) != 0;
      delay = $urandom % 4;
      rdBase = 8'($urandom);
      n = nBytes(a, sz);
      gate = ((ctl & 8'h2F) == (wr ? 8'h04 : 8'h24));
      access(wr, a, sz, wd, rd);
      if (!gate) chk("R3 R4 random gate", attempts - att0, 0);
      else if (respond) begin
        chk("R6 random bytes", ptr - ptr0, n);
        if (wr) begin
          for (int k = 0; k < n; k++)
            chk("R6 random wbyte", logData[(ptr0+k)%8], wd[k*8 +: 8]);
        end else chk("R6 random read", rd, seqW(rdBase, n));
      end else begin
        expTmo = 1;
        chk("R8 random abandon", attempts - att0, 1);
        if (!wr) chk("R8 random ones", rd, onesW(n));
      end
      if (gate && !wr && !respond) ; else if (!gate && !wr) chk("R4 random ones", rd, onesW(n));
      if (($urandom % 4) == 0) begin
        access(0, 3'd1, 0, 0, rd); chk("R9 random status", rd, {31'b0, expTmo});
        if ($urandom % 2) begin
          access(1, 3'd1, 0, 32'h01, rd); expTmo = 0;
        end
      end
    end
    summary();
  end
endmodule